// File: doc/BRIEF.md
# Saturating Second-Order Recursive Filter

This block is a second-order recursive filter section in Direct Form I for one signed 14-bit sampled channel. It takes one new sample on every clock and returns one filtered sample per clock. Because it keeps two delayed inputs and two delayed outputs in separate tap lines, the feedforward gain can be set without changing the internal feedback state. Five signed fixed-point coefficients arrive on static input ports that a register file upstream drives.

Each cycle the section forms the full-precision sum b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. It rounds away the fractional bits and limits the result to the 14-bit range. The limited value goes to the output and into the output tap line. When limiting occurs, a sticky flag rises. A small two-state machine (`SAT_CLEAR`, `SAT_HELD`) holds the flag until a clear request arrives. The machine moves from `SAT_CLEAR` to `SAT_HELD` when a sample is limited. It moves from `SAT_HELD` to `SAT_CLEAR` when the clear input is high and no sample is limited in that cycle. In every other case it stays in its state.

Top module: `dfi_biquad`

## Requirements
- R1: The block accepts a sample on every rising clock edge. The output for the sample on `x_in` at one edge appears on `y_out` right after that edge, so latency is one cycle and throughput is one sample per clock.
- R2: The output is y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. The feedback products are subtracted.
- R3: Each coefficient is an 18-bit two's-complement value with 16 fractional bits. The value +1.0 is 65536 and the most negative code −131072 is −2.0. The a1 port therefore reaches magnitude 2, and the other coefficients are used within ±1.
- R4: The full-precision sum is rounded to the nearest integer by adding 2^15 and then shifting right arithmetically by 16. Ties therefore round toward +infinity: 0.5→1, −0.5→0, 1.5→2, −1.5→−1.
- R5: A rounded result above 8191 is output as 8191. A result below −8192 is output as −8192. The output never wraps.
- R6: The limited value, not the unlimited sum, is what enters the y[n-1] and y[n-2] delays.
- R7: `sat_flag` goes high after the edge that loads a limited sample, in the same cycle that sample shows on `y_out`. It stays high while `sat_clr` is low.
- R8: With `sat_clr` high at an edge, `sat_flag` is low after that edge unless that same edge loads a limited sample. If it does, the flag stays high.
- R9: An active-low asynchronous reset clears all four delay taps, `y_out` and `sat_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sat_clr | input | 1 | Request to clear the sticky limit flag |
| x_in | input | 14 | Signed input sample |
| coef_b0 | input | 18 | Feedforward coefficient for x[n], Q2.16 |
| coef_b1 | input | 18 | Feedforward coefficient for x[n-1], Q2.16 |
| coef_b2 | input | 18 | Feedforward coefficient for x[n-2], Q2.16 |
| coef_a1 | input | 18 | Feedback coefficient for y[n-1], Q2.16 |
| coef_a2 | input | 18 | Feedback coefficient for y[n-2], Q2.16 |
| y_out | output | 14 | Signed filtered, limited output sample |
| sat_flag | output | 1 | Sticky limit indicator |

## Verification
Each filtered sample and its limit flag are due one edge after the input and the clear request are applied. The driver applies a sample at a falling edge and queues the matching output and flag, which a bit-exact model computes, including the rounding and the limited feedback. The monitor pops one entry per rising edge, one time unit after that edge, so every comparison sees the registers loaded from exactly the queued sample. Reset values are asynchronous and are checked while reset is still held.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    // default geometry of the section
    localparam int SAMPLE_W  = 14;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 16;
    localparam int N_TERMS   = 5;   // three feedforward, two feedback
    localparam int N_FWD     = 3;

    // sticky limit indicator
    typedef enum logic {
        SAT_CLEAR = 1'b0,
        SAT_HELD  = 1'b1
    } sat_state_e;

endpackage

// File: rtl/biquad_taps.sv
module biquad_taps #(
    parameter int W     = 14,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              d_i,
    output logic [DEPTH-1:0][W-1:0]   q_o
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [W-1:0] src;
        if (i == 0) begin : g_head
            assign src = d_i;
        end else begin : g_body
            assign src = q_o[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= '0;
            end else begin
                q_o[i] <= src;
            end
        end
    end

endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
    parameter int DATA_W = biquad_pkg::SAMPLE_W,
    parameter int COEF_W = biquad_pkg::COEF_W,
    parameter int NT     = biquad_pkg::N_TERMS,
    parameter int NF     = biquad_pkg::N_FWD,
    parameter int ACC_W  = DATA_W + COEF_W + 3
) (
    input  logic [NT-1:0][DATA_W-1:0] samp_i,
    input  logic [NT-1:0][COEF_W-1:0] coef_i,
    output logic signed [ACC_W-1:0]   acc_o
);

    logic signed [ACC_W-1:0] term [NT];

    for (genvar i = 0; i < NT; i++) begin : g_term
        logic signed [ACC_W-1:0] s_ext;
        logic signed [ACC_W-1:0] c_ext;
        logic signed [ACC_W-1:0] prod;

        assign s_ext = {{(ACC_W-DATA_W){samp_i[i][DATA_W-1]}}, samp_i[i]};
        assign c_ext = {{(ACC_W-COEF_W){coef_i[i][COEF_W-1]}}, coef_i[i]};
        assign prod  = s_ext * c_ext;

        if (i < NF) begin : g_fwd
            assign term[i] = prod;
        end else begin : g_fbk
            assign term[i] = -prod;
        end
    end

    always_comb begin
        acc_o = '0;
        for (int k = 0; k < NT; k++) begin
            acc_o = acc_o + term[k];
        end
    end

endmodule

// File: rtl/biquad_clip.sv
module biquad_clip #(
    parameter int DATA_W = biquad_pkg::SAMPLE_W,
    parameter int FRAC   = biquad_pkg::COEF_FRAC,
    parameter int ACC_W  = 35
) (
    input  logic signed [ACC_W-1:0]  acc_i,
    output logic [DATA_W-1:0]        y_o,
    output logic                     hit_o
);

    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) << (FRAC-1);
    localparam logic signed [ACC_W-1:0] OUT_MAX =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] whole;

    assign rnd   = acc_i + HALF;
    assign whole = rnd >>> FRAC;

    always_comb begin
        if (whole > OUT_MAX) begin
            y_o   = OUT_MAX[DATA_W-1:0];
            hit_o = 1'b1;
        end else if (whole < OUT_MIN) begin
            y_o   = OUT_MIN[DATA_W-1:0];
            hit_o = 1'b1;
        end else begin
            y_o   = whole[DATA_W-1:0];
            hit_o = 1'b0;
        end
    end

endmodule

// File: rtl/biquad_satflag.sv
module biquad_satflag
    import biquad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);

    sat_state_e state_q;
    sat_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SAT_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SAT_CLEAR: if (hit_i)           state_d = SAT_HELD;
            SAT_HELD:  if (clr_i && !hit_i) state_d = SAT_CLEAR;
            default:                        state_d = SAT_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == SAT_HELD);
    end

endmodule

// File: rtl/dfi_biquad.sv
module dfi_biquad #(
    parameter int DATA_W = biquad_pkg::SAMPLE_W,
    parameter int COEF_W = biquad_pkg::COEF_W,
    parameter int FRAC   = biquad_pkg::COEF_FRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sat_clr,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [COEF_W-1:0] coef_b0,
    input  logic signed [COEF_W-1:0] coef_b1,
    input  logic signed [COEF_W-1:0] coef_b2,
    input  logic signed [COEF_W-1:0] coef_a1,
    input  logic signed [COEF_W-1:0] coef_a2,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     sat_flag
);

    localparam int NT    = biquad_pkg::N_TERMS;
    localparam int ACC_W = DATA_W + COEF_W + 3;

    logic [1:0][DATA_W-1:0]  x_taps;
    logic [1:0][DATA_W-1:0]  y_taps;
    logic [DATA_W-1:0]       x_d1;
    logic [DATA_W-1:0]       x_d2;
    logic [DATA_W-1:0]       y_d2;
    logic [DATA_W-1:0]       y_next;
    logic                    clip_hit;
    logic signed [ACC_W-1:0] acc;
    logic [NT-1:0][DATA_W-1:0] samp;
    logic [NT-1:0][COEF_W-1:0] coef;

    biquad_taps #(.W(DATA_W), .DEPTH(2)) u_xtaps (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (x_in),
        .q_o   (x_taps)
    );

    // output delay line is fed from the limited value
    biquad_taps #(.W(DATA_W), .DEPTH(2)) u_ytaps (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (y_next),
        .q_o   (y_taps)
    );

    assign x_d1  = x_taps[0];
    assign x_d2  = x_taps[1];
    assign y_d2  = y_taps[1];
    assign y_out = y_taps[0];

    assign samp = {y_d2, y_out, x_d2, x_d1, x_in};
    assign coef = {coef_a2, coef_a1, coef_b2, coef_b1, coef_b0};

    biquad_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .NT     (NT),
        .NF     (biquad_pkg::N_FWD),
        .ACC_W  (ACC_W)
    ) u_mac (
        .samp_i (samp),
        .coef_i (coef),
        .acc_o  (acc)
    );

    biquad_clip #(
        .DATA_W (DATA_W),
        .FRAC   (FRAC),
        .ACC_W  (ACC_W)
    ) u_clip (
        .acc_i  (acc),
        .y_o    (y_next),
        .hit_o  (clip_hit)
    );

    biquad_satflag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (clip_hit),
        .clr_i  (sat_clr),
        .flag_o (sat_flag)
    );

endmodule

// File: rtl/biquad_sva.sv
module biquad_sva #(
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sat_clr,
    input logic [DATA_W-1:0] x_in,
    input logic [DATA_W-1:0] x_d1,
    input logic [DATA_W-1:0] x_d2,
    input logic [DATA_W-1:0] y_out,
    input logic [DATA_W-1:0] y_d2,
    input logic              sat_flag,
    input logic              clip_hit
);

    localparam logic [DATA_W-1:0] TOP = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] BOT = {1'b1, {(DATA_W-1){1'b0}}};

    // R5: a newly raised flag always comes with a full-scale output
    a_r5_rise_fullscale: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> (y_out == TOP || y_out == BOT));

    // R7: flag holds while no clear is requested
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);

    // R7: flag never rises without a limited sample
    a_r7_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag && !clip_hit) |=> !sat_flag);

    // R8: clear without a concurrent limit drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !clip_hit) |=> !sat_flag);

    // R2: an all-zero state and input yields a zero output
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (x_in == '0 && x_d1 == '0 && x_d2 == '0 && y_out == '0 && y_d2 == '0)
        |=> (y_out == '0));

endmodule

bind dfi_biquad biquad_sva #(.DATA_W(DATA_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .sat_clr  (sat_clr),
    .x_in     (x_in),
    .x_d1     (x_d1),
    .x_d2     (x_d2),
    .y_out    (y_out),
    .y_d2     (y_d2),
    .sat_flag (sat_flag),
    .clip_hit (clip_hit)
);

// File: tb/sim_dfi_biquad.sv
module sim_dfi_biquad;

    localparam int CLK_PERIOD = 10;
    localparam int ONE        = 65536;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sat_clr = 1'b0;
    logic signed [13:0] x_in = '0;
    logic signed [17:0] coef_b0 = '0, coef_b1 = '0, coef_b2 = '0;
    logic signed [17:0] coef_a1 = '0, coef_a2 = '0;
    logic signed [13:0] y_out;
    logic               sat_flag;

    int total = 0;
    int bad   = 0;

    // bench copies of the coefficients, applied together with each sample
    int cb0 = 0, cb1 = 0, cb2 = 0, ca1 = 0, ca2 = 0;

    // reference state
    longint m_x1 = 0, m_x2 = 0, m_y1 = 0, m_y2 = 0;
    bit     m_flag = 1'b0;

    // scoreboard
    int    exp_y[$];
    bit    exp_f[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dfi_biquad u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sat_clr  (sat_clr),
        .x_in     (x_in),
        .coef_b0  (coef_b0),
        .coef_b1  (coef_b1),
        .coef_b2  (coef_b2),
        .coef_a1  (coef_a1),
        .coef_a2  (coef_a2),
        .y_out    (y_out),
        .sat_flag (sat_flag)
    );

    task automatic set_coef(int b0, int b1, int b2, int a1, int a2);
        cb0 = b0; cb1 = b1; cb2 = b2; ca1 = a1; ca2 = a2;
    endtask

    task automatic model_reset();
        m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; m_flag = 1'b0;
    endtask

    // driver: apply one sample and queue its expected result
    task automatic push(int x, bit clr, string tag);
        longint acc, r;
        bit     hit;
        @(negedge clk);
        x_in    = 14'(x);
        sat_clr = clr;
        coef_b0 = 18'(cb0); coef_b1 = 18'(cb1); coef_b2 = 18'(cb2);
        coef_a1 = 18'(ca1); coef_a2 = 18'(ca2);
        acc = longint'(cb0) * x + longint'(cb1) * m_x1 + longint'(cb2) * m_x2
            - longint'(ca1) * m_y1 - longint'(ca2) * m_y2;
        r   = (acc + 32768) >>> 16;
        hit = 1'b0;
        if (r > 8191)  begin r = 8191;  hit = 1'b1; end
        if (r < -8192) begin r = -8192; hit = 1'b1; end
        m_flag = hit | (m_flag & ~clr);
        m_x2 = m_x1; m_x1 = x;
        m_y2 = m_y1; m_y1 = r;
        exp_y.push_back(int'(r));
        exp_f.push_back(m_flag);
        exp_tag.push_back(tag);
    endtask

    task automatic do_reset();
        while (exp_y.size() > 0) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b0;
        x_in    = '0;
        sat_clr = 1'b0;
        model_reset();
        #1;
        total++;
        if (y_out !== 14'sd0 || sat_flag !== 1'b0) begin
            bad++;
            $display("FAIL R9 reset: y_out=%0d flag=%0b expected y_out=0 flag=0",
                     y_out, sat_flag);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: one expected item per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_y.size() > 0) begin
                int    ey;
                bit    ef;
                string et;
                ey = exp_y.pop_front();
                ef = exp_f.pop_front();
                et = exp_tag.pop_front();
                total++;
                if (int'(y_out) != ey || sat_flag !== ef) begin
                    bad++;
                    $display("FAIL %s: y_out=%0d flag=%0b expected y_out=%0d flag=%0b",
                             et, y_out, sat_flag, ey, ef);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: state after power-up reset
        do_reset();

        // R1 R2: pure feedforward impulse, one result per clock
        set_coef(ONE/2, ONE/4, ONE/8, 0, 0);
        push(4000, 1'b0, "R1 impulse n0");
        push(0,    1'b0, "R1 impulse n1");
        push(0,    1'b0, "R2 impulse n2");
        push(0,    1'b0, "R2 impulse tail");
        push(-6000, 1'b0, "R2 negative impulse");
        push(3000, 1'b0, "R2 mixed taps");

        // R4: rounding of half values
        do_reset();
        set_coef(ONE/2, 0, 0, 0, 0);
        push(1,  1'b0, "R4 +0.5 to 1");
        push(-1, 1'b0, "R4 -0.5 to 0");
        push(3,  1'b0, "R4 +1.5 to 2");
        push(-3, 1'b0, "R4 -1.5 to -1");
        push(5,  1'b0, "R4 +2.5 to 3");

        // R2: step into a section with feedback
        do_reset();
        set_coef(ONE/4, 0, 0, -98304, 36864);
        for (int i = 0; i < 12; i++) push(1000, 1'b0, "R2 step with feedback");

        // R3: a1 at -2.0 in the wide format
        do_reset();
        set_coef(ONE/8, 0, 0, -131072, 64880);
        push(2000, 1'b0, "R3 a1 minus two impulse");
        for (int i = 0; i < 10; i++) push(0, 1'b0, "R3 a1 minus two ringing");

        // R5 R7: full-scale input with unit gains
        do_reset();
        set_coef(ONE, ONE, ONE, 0, 0);
        push(8191, 1'b0, "R5 full scale first");
        push(8191, 1'b0, "R5 positive clip");
        push(8191, 1'b0, "R5 positive clip hold");
        push(-8192, 1'b0, "R5 swing");
        push(-8192, 1'b0, "R5 swing2");
        push(-8192, 1'b0, "R5 negative clip");
        push(0, 1'b0, "R7 sticky after clip");
        push(0, 1'b0, "R7 sticky quiet");
        push(0, 1'b0, "R7 sticky quiet2");
        push(0, 1'b1, "R8 clear");
        push(0, 1'b0, "R8 stays clear");
        push(8191, 1'b0, "R7 no clip no flag");
        push(8191, 1'b1, "R8 clip wins over clear");
        push(0, 1'b0, "R7 sticky after set-wins");

        // R6: limited value is what feeds back (y = x + y[n-1])
        do_reset();
        set_coef(ONE, 0, 0, -ONE, 0);
        for (int i = 0; i < 5; i++) push(4000, 1'b0, "R6 limited feedback");
        for (int i = 0; i < 3; i++) push(-4000, 1'b0, "R6 descend from clip");

        // R9: reset in the middle of a stream
        push(1234, 1'b0, "R9 before reset");
        do_reset();
        set_coef(ONE, 0, 0, 0, 0);
        push(0, 1'b0, "R9 quiet after reset");

        while (exp_y.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule